// File: doc/BRIEF.md
# Register-Driven SPI Shift Engine

A SPI master built around one shift command. Software writes up to 32 bits of outgoing data into a transmit register. It then writes a shift-control word, and that write starts the transfer. Each command carries three things of its own: which chip select to drive, how many bits to move, and whether the chip select is released when the command ends. Because the chip select can stay asserted from one command to the next, a message longer than 32 bits is sent as a series of chunks.

The serial clock comes from the system clock through a 6-bit divider. The bus runs in SPI mode 0 and sends the most significant bit first. The receive register collects the bits read from the input line. The start bit in the shift-control word stays set while a shift runs and clears itself when the shift ends, so software finds out that a command is done by polling that bit. A pin-control register sets the levels of the chip selects, the clock and the data output while no shift is running. A function-select bit must be set before software can reach any other register.

Top module: `spi_shift_engine`

## Requirements
- R1: Bit 0 of the function-select register (offset 0x00, reset 0) gates every other register. While it is 0, writes to offsets 0x04, 0x08, 0x10 and 0x14 have no effect, and reads of those offsets and of 0x18 return 0.
- R2: The pin-control register (offset 0x08) resets to 0x0007_0000. While no shift runs and no chip select is held, the chip-select outputs follow bits 18:16 (bit 16 for chip select 0), the serial clock follows bit 8 and the data output follows bit 0.
- R3: The control register (offset 0x04) holds a divider value d in bits 5:0. The serial clock stays high for d+1 system cycles and low for d+1 cycles. A command of N bits keeps the start bit set for 2·N·(d+1) cycles. Writes to the control register during a shift are ignored.
- R4: The shift-control word (offset 0x14) uses these fields: bit 31 starts a shift, bits 30:28 select chip selects 2..0, bit 26 is the terminate flag, and bits 5:0 give the bit count (8, 16, 24 or 32). When read back, bit 31 is 1 while the shift runs and 0 after it. The other fields read back as written.
- R5: Transmit data (offset 0x10) is right-aligned. For N bits, bit N-1 is sent first, and bit 0 is sent last.
- R6: The bus runs in mode 0. The serial clock idles low, the data output changes only when the clock falls, and the input line is sampled when the clock rises.
- R7: The receive register (offset 0x18) holds the received bits right-aligned, with the last bit received in bit 0 and the bits above the count at 0. It changes only when a shift completes.
- R8: Chip selects are active low. The selected chip select is driven low from the start of the command. With terminate set, it goes high after the last bit. With terminate clear, it stays low after completion until a later command ends with terminate set.
- R9: A shift-control write that arrives while a shift runs is ignored. It does not restart the transfer, change its length or change its chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 3 | Chip selects, active low |

## Verification
The bench uses the default parameters: a 6-bit divider, 6-bit count field and three chip selects. Directed runs use the divider at 0 and at its maximum of 63, which gives the slowest clock of 128 system cycles per bit. With the 6-bit count field, every supported length from 8 to 32 bits can be reached, so the alignment of the transmit and receive fields is exercised at each size. Random runs vary the divider, the length, the chip select and the data. A device model on the bench sends data on the falling clock edge. Because of this, an engine that sampled on the wrong edge would capture shifted data, and the bench would see it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int XLEN = 32;

  localparam logic [7:0] ADDR_FUNC  = 8'h00;
  localparam logic [7:0] ADDR_CTRL  = 8'h04;
  localparam logic [7:0] ADDR_PINS  = 8'h08;
  localparam logic [7:0] ADDR_TXD   = 8'h10;
  localparam logic [7:0] ADDR_SHIFT = 8'h14;
  localparam logic [7:0] ADDR_RXD   = 8'h18;

  localparam int SH_GO      = 31;
  localparam int SH_CS_LSB  = 28;
  localparam int SH_TERM    = 26;
  localparam int PIN_DO     = 0;
  localparam int PIN_CLK    = 8;
  localparam int PIN_CS_LSB = 16;

  localparam logic [XLEN-1:0] PIN_RESET = 32'h0007_0000;
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int CNT_W  = 6,
  parameter int NUM_CS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   rdata_o,
  input  logic              busy_i,
  input  logic [XLEN-1:0]   rx_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              pin_do_o,
  output logic              pin_clk_o,
  output logic [NUM_CS-1:0] pin_cs_o,
  output logic [XLEN-1:0]   tx_o,
  output logic              go_o,
  output logic [NUM_CS-1:0] go_cs_o,
  output logic              go_term_o,
  output logic [CNT_W-1:0]  go_nbits_o
);
  localparam int SHW = $clog2(XLEN) + 1;

  logic              fs_en_q;
  logic [DIV_W-1:0]  div_q;
  logic [XLEN-1:0]   pins_q, tx_q;
  logic [NUM_CS-1:0] cmd_cs_q;
  logic              cmd_term_q;
  logic [CNT_W-1:0]  cmd_cnt_q;
  logic              wr_ok;
  logic [CNT_W-1:0]  raw_cnt;

  assign wr_ok   = we_i && fs_en_q;
  assign raw_cnt = wdata_i[CNT_W-1:0];
  assign go_o    = wr_ok && (addr_i == ADDR_SHIFT) && wdata_i[SH_GO] && !busy_i;
  assign go_cs_o = wdata_i[SH_CS_LSB +: NUM_CS];
  assign go_term_o = wdata_i[SH_TERM];
  // count 0 or beyond the register width runs a full word
  assign go_nbits_o = (raw_cnt == '0 || SHW'(raw_cnt) > SHW'(XLEN)) ? CNT_W'(XLEN) : raw_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_en_q    <= 1'b0;
      div_q      <= '0;
      pins_q     <= PIN_RESET;
      tx_q       <= '0;
      cmd_cs_q   <= '0;
      cmd_term_q <= 1'b0;
      cmd_cnt_q  <= '0;
    end else begin
      if (we_i && addr_i == ADDR_FUNC) fs_en_q <= wdata_i[0];
      if (wr_ok && addr_i == ADDR_CTRL && !busy_i) div_q <= wdata_i[DIV_W-1:0];
      if (wr_ok && addr_i == ADDR_PINS) pins_q <= wdata_i;
      if (wr_ok && addr_i == ADDR_TXD) tx_q <= wdata_i;
      if (go_o) begin
        cmd_cs_q   <= go_cs_o;
        cmd_term_q <= go_term_o;
        cmd_cnt_q  <= raw_cnt;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_FUNC) begin
      rdata_o[0] = fs_en_q;
    end else if (fs_en_q) begin
      unique case (addr_i)
        ADDR_CTRL:  rdata_o[DIV_W-1:0] = div_q;
        ADDR_PINS:  rdata_o = pins_q;
        ADDR_TXD:   rdata_o = tx_q;
        ADDR_RXD:   rdata_o = rx_i;
        ADDR_SHIFT: begin
          rdata_o[SH_GO]                 = busy_i;
          rdata_o[SH_CS_LSB +: NUM_CS]   = cmd_cs_q;
          rdata_o[SH_TERM]               = cmd_term_q;
          rdata_o[CNT_W-1:0]             = cmd_cnt_q;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign div_o     = div_q;
  assign pin_do_o  = pins_q[PIN_DO];
  assign pin_clk_o = pins_q[PIN_CLK];
  assign pin_cs_o  = pins_q[PIN_CS_LSB +: NUM_CS];
  assign tx_o      = tx_q;

  AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(div_q)); // R3
  AST_GATED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fs_en_q) && $past(addr_i) != ADDR_FUNC |-> $stable(tx_q) && $stable(pins_q)); // R1
endmodule

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= div_i); // R3
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int NUM_CS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [NUM_CS-1:0] cs_i,
  input  logic              term_i,
  input  logic [XLEN-1:0]   tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_act_o,
  output logic [XLEN-1:0]   rx_o
);
  localparam int SHW = $clog2(XLEN) + 1;

  logic              busy_q, sclk_q, term_q;
  logic [XLEN-1:0]   sh_q, in_q, rx_q;
  logic [CNT_W-1:0]  left_q;
  logic [NUM_CS-1:0] cs_q;
  logic [SHW-1:0]    pre_shift;

  assign pre_shift = SHW'(XLEN) - SHW'(nbits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      term_q <= 1'b0;
      sh_q   <= '0;
      in_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
      cs_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      term_q <= term_i;
      cs_q   <= cs_i;
      sh_q   <= tx_i << pre_shift;  // first bit into the MSB
      in_q   <= '0;
      left_q <= nbits_i;
    end else if (busy_q && tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        in_q   <= {in_q[XLEN-2:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          rx_q   <= in_q;
          if (term_q) cs_q <= '0;
        end else begin
          sh_q   <= sh_q << 1;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = sh_q[XLEN-1];
  assign cs_act_o = cs_q;
  assign rx_o     = rx_q;

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && sclk_q && $past(sclk_q) |-> $stable(sh_q[XLEN-1])); // R6
  AST_TERM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) && term_q |-> cs_q == '0); // R8
  AST_HOLD_KEEPS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) && !term_q |-> cs_q == $past(cs_q)); // R8
  AST_RX_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_q) |-> $fell(busy_q)); // R7
  AST_GO_WHILE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R9
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int CNT_W  = 6,
  parameter int NUM_CS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  logic              busy, tick, go, go_term, pin_do, pin_clk, sh_sclk, sh_mosi;
  logic [DIV_W-1:0]  div;
  logic [CNT_W-1:0]  go_nbits;
  logic [NUM_CS-1:0] go_cs, pin_cs, cs_act;
  logic [XLEN-1:0]   tx, rx;

  spi_eng_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W), .NUM_CS(NUM_CS)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .rx_i(rx), .div_o(div), .pin_do_o(pin_do), .pin_clk_o(pin_clk),
    .pin_cs_o(pin_cs), .tx_o(tx), .go_o(go), .go_cs_o(go_cs), .go_term_o(go_term),
    .go_nbits_o(go_nbits)
  );

  spi_eng_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .en_i(busy), .div_i(div), .tick_o(tick)
  );

  spi_eng_shifter #(.CNT_W(CNT_W), .NUM_CS(NUM_CS)) u_shift (
    .clk_i, .rst_ni, .start_i(go), .nbits_i(go_nbits), .cs_i(go_cs), .term_i(go_term),
    .tx_i(tx), .tick_i(tick), .miso_i, .busy_o(busy), .sclk_o(sh_sclk), .mosi_o(sh_mosi),
    .cs_act_o(cs_act), .rx_o(rx)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_no[i] = cs_act[i] ? 1'b0 : pin_cs[i];
  end

  assign sclk_o = busy ? sh_sclk : pin_clk;
  assign mosi_o = busy ? sh_mosi : pin_do;

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && cs_act == '0 |-> cs_no == pin_cs && sclk_o == pin_clk); // R2
endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sclk_o, mosi_o, miso_i;
  logic [2:0]  cs_no;

  int n_chk = 0, n_fail = 0;
  logic [31:0] slv = '0;
  logic [31:0] mosi_cap = '0;
  int rises = 0, viol = 0;
  bit in_shift = 1'b0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;

  always #5 clk_i = ~clk_i;

  spi_shift_engine u_dut (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .sclk_o, .mosi_o, .miso_i, .cs_no
  );

  assign miso_i = slv[31];

  always @(posedge sclk_o) if (in_shift) begin
    mosi_cap = {mosi_cap[30:0], mosi_o};
    rises++;
  end
  always @(negedge sclk_o) if (in_shift) slv = slv << 1;

  always @(negedge clk_i) begin
    if (in_shift && sclk_o && prev_sclk && mosi_o != prev_mosi) viol++;
    prev_sclk = sclk_o;
    prev_mosi = mosi_o;
  end

  function automatic logic [31:0] fmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; #1; d = rdata_o;
  endtask

  task automatic do_shift(int d, int n, int csn, bit term, logic [31:0] tx,
                          logic [31:0] sl, bit inject);
    logic [31:0] r;
    logic [2:0] exp_cs;
    int cycles, hi, cs_bad;
    exp_cs = ~(3'b001 << csn);
    wr(8'h04, 32'(d));
    wr(8'h10, tx);
    slv = sl << (32 - n);
    mosi_cap = '0; rises = 0; viol = 0; in_shift = 1'b1;
    wr(8'h14, 32'h8000_0000 | (32'h1 << (28 + csn)) | (32'(term) << 26) | 32'(n));
    cycles = 0; hi = 0; cs_bad = 0;
    addr_i = 8'h14; #1;
    while (rdata_o[31] || (inject && cycles >= 10 && cycles <= 12)) begin
      cycles++;
      hi += int'(sclk_o);
      if (cs_no != exp_cs) cs_bad++;
      @(negedge clk_i);
      if (inject && cycles == 10) begin
        we_i = 1'b1; addr_i = 8'h14; wdata_i = 32'h8000_0000 | (32'h1 << 30) | 32'd8;
      end else if (inject && cycles == 11) begin
        addr_i = 8'h04; wdata_i = 32'd7;
      end else if (inject && cycles == 12) begin
        we_i = 1'b0; addr_i = 8'h14;
      end
      #1;
    end
    in_shift = 1'b0;
    chk(cycles == 2 * n * (d + 1), "R3 start-bit duration", 32'(cycles), 32'(2 * n * (d + 1)));
    chk(hi == n * (d + 1), "R3 clock high cycles", 32'(hi), 32'(n * (d + 1)));
    chk(cs_bad == 0, "R8 chip select during shift", 32'(cs_bad), 32'd0);
    chk(rises == n, "R6 clock edges", 32'(rises), 32'(n));
    chk(viol == 0, "R6 data change while clock high", 32'(viol), 32'd0);
    chk((mosi_cap & fmask(n)) == (tx & fmask(n)), "R5 transmit order",
        mosi_cap & fmask(n), tx & fmask(n));
    rd(8'h18, r);
    chk(r == (sl & fmask(n)), "R7 receive data", r, sl & fmask(n));
    chk(cs_no == (term ? 3'b111 : exp_cs), "R8 chip select after shift",
        32'(cs_no), 32'(term ? 3'b111 : exp_cs));
    chk(sclk_o == 1'b0, "R6 clock idle low", 32'(sclk_o), 32'd0);
    if (inject) begin
      rd(8'h04, r);
      chk(r == 32'(d), "R3 divider write ignored during shift", r, 32'(d));
      repeat (4) @(negedge clk_i);
      rd(8'h14, r);
      chk(r[31] == 1'b0, "R9 no restart from ignored write", r, 32'h0);
      chk(cs_no == 3'b111, "R9 ignored write left chip selects", 32'(cs_no), 32'h7);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no == 3'b111 && sclk_o == 1'b0 && mosi_o == 1'b0, "R2 reset pins",
        {28'h0, cs_no, sclk_o}, 32'he);
    rd(8'h08, r);
    chk(r == 32'h0, "R1 read gated", r, 32'h0);
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h00, 32'h1);
    rd(8'h10, r);
    chk(r == 32'h0, "R1 write gated", r, 32'h0);
    rd(8'h08, r);
    chk(r == 32'h0007_0000, "R2 pin-control reset value", r, 32'h0007_0000);
    wr(8'h08, 32'h0002_0101);
    @(negedge clk_i);
    chk(cs_no == 3'b010 && sclk_o && mosi_o, "R2 idle pins follow register",
        {28'h0, cs_no, sclk_o}, 32'h5);
    wr(8'h08, 32'h0007_0000);

    do_shift(0, 8, 0, 1'b1, 32'h0000_00A5, 32'h0000_003C, 1'b0);
    do_shift(63, 8, 2, 1'b1, 32'h0000_0081, 32'h0000_00C3, 1'b0);
    do_shift(1, 32, 1, 1'b1, 32'h8123_4567, 32'hF0E1_D2C3, 1'b0);
    do_shift(0, 24, 0, 1'b1, 32'hFF12_3456, 32'h00AB_CDEF, 1'b0);

    do_shift(2, 16, 1, 1'b0, 32'h0000_1234, 32'h0000_BEEF, 1'b0);
    rd(8'h14, r);
    chk(r == 32'h2000_0010, "R4 shift-control readback", r, 32'h2000_0010);
    repeat (5) @(negedge clk_i);
    chk(cs_no == 3'b101, "R8 chip select held between commands", 32'(cs_no), 32'h5);
    do_shift(2, 8, 1, 1'b1, 32'h0000_0055, 32'h0000_0099, 1'b0);
    rd(8'h14, r);
    chk(r == 32'h2400_0008, "R4 shift-control readback after end", r, 32'h2400_0008);

    do_shift(3, 16, 0, 1'b1, 32'h0000_C0DE, 32'h0000_5A5A, 1'b1);

    for (int i = 0; i < 16; i++) begin
      do_shift(int'($urandom % 4), 8 * (1 + int'($urandom % 4)), int'($urandom % 3),
               1'b1, $urandom, $urandom, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule